// File: doc/BRIEF.md
# Fault-Injectable Lookup Table Cell

This block is a K-input lookup table whose Boolean function is taken from a 2^K-bit golden initialisation word. The input vector, read as a binary address, selects one bit of the table contents, and that bit is the cell output. A fault-injection control can replace the golden contents with a deliberately corrupted table. The corruption can invert one table bit, tie one input to a constant, or tie the output to a constant. Only one fault is active at any time.

Every fault is applied by rewriting the contents word and never by gating the inputs or the output. As a result, each fault description reduces to one effective contents word, and the cell exports that word. A fault campaign can compare the exported words of two descriptions. When the words are equal, the two faults are the same, and one of them can be dropped as a duplicate.

The effective contents are formed combinationally from the current controls. The output bit and the exported word are registered together, so both appear one clock after the inputs are presented.

Top module: `lutf_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, `lut_out` and `eff_word` become 0 after that edge.
- R2: With `fault_mode` = 0 (no fault), `eff_word` equals `init_word` one cycle after it is presented.
- R3: With `fault_mode` = 1 (bit inversion), `eff_word` equals `init_word` with exactly bit `fault_idx` inverted (for example, 8'hFE with bit 7 inverted gives 8'h7E).
- R4: With `fault_mode` = 2 (input stuck) and `fault_idx` < K, every address a of `eff_word` holds the `init_word` bit at address a with bit `fault_idx` replaced by `stuck_val`.
- R5: With `fault_mode` = 2 and `fault_idx` >= K, `eff_word` equals `init_word` unchanged.
- R6: With `fault_mode` = 3 (output stuck), every bit of `eff_word` equals `stuck_val`.
- R7: `lut_out` equals bit `lut_in` of `eff_word`, where both refer to the same presented inputs and both are registered with one cycle of latency.
- R8: Two fault descriptions that disturb the function in the same way produce identical `eff_word` values. For example, inverting bit 0 of 8'hFE and stuck-at-1 on the output both give 8'hFF, and inverting bit 7 gives a different word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lut_in | input | K | Data inputs, used as the table address |
| init_word | input | 2^K | Golden table contents |
| fault_mode | input | 2 | Fault kind: 0 none, 1 bit inversion, 2 input stuck, 3 output stuck |
| fault_idx | input | K | Bit index for mode 1, input index for mode 2 |
| stuck_val | input | 1 | Forced value for modes 2 and 3 |
| lut_out | output | 1 | Registered cell output |
| eff_word | output | 2^K | Registered effective contents |

## Verification
The assertions assume that the controls are held steady for a full clock period and that they change only between edges. The bench drives them on the falling edge, so each control set is captured whole at one rising edge. The assertions also assume that no two faults are meant at once. The mode field encodes exactly one fault by construction, so the stimulus cannot present two faults together. For bit inversion, any index value is legal, because K bits span exactly the 2^K table addresses. For input stuck, the stimulus deliberately uses an out-of-range index so that the unchanged-contents case is reached.

// File: rtl/lutf_pkg.sv
package lutf_pkg;
  typedef enum logic [1:0] {
    FM_NONE      = 2'd0,
    FM_FLIP      = 2'd1,
    FM_IN_STUCK  = 2'd2,
    FM_OUT_STUCK = 2'd3
  } fmode_e;
endpackage

// File: rtl/lutf_fault_map.sv
// Builds the effective table contents for the selected fault.
module lutf_fault_map #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0]         init_word,
  input  lutf_pkg::fmode_e     mode,
  input  logic [K-1:0]         idx,
  input  logic                 sval,
  output logic [N-1:0]         eff
);
  logic idx_in_range;
  logic [K-1:0] idx_mask;

  assign idx_in_range = (32'(idx) < K);
  assign idx_mask     = K'(1) << idx;

  for (genvar a = 0; a < N; a++) begin : g_addr
    localparam logic [K-1:0] ADDR = K'(a);
    logic [K-1:0] addr_hi;
    logic [K-1:0] addr_lo;
    assign addr_hi = ADDR | idx_mask;
    assign addr_lo = ADDR & ~idx_mask;

    always_comb begin
      unique case (mode)
        lutf_pkg::FM_NONE:      eff[a] = init_word[a];
        lutf_pkg::FM_FLIP:      eff[a] = init_word[a] ^ (idx == ADDR);
        lutf_pkg::FM_IN_STUCK:  eff[a] = idx_in_range ? init_word[sval ? addr_hi : addr_lo]
                                                      : init_word[a];
        lutf_pkg::FM_OUT_STUCK: eff[a] = sval;
        default:                eff[a] = init_word[a];
      endcase
    end
  end
endmodule

// File: rtl/lutf_select.sv
// Picks the table bit addressed by the input vector.
module lutf_select #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] table_bits,
  input  logic [K-1:0] addr,
  output logic         bit_out
);
  assign bit_out = table_bits[addr];
endmodule

// File: rtl/lutf_cell.sv
module lutf_cell #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] lut_in,
  input  logic [N-1:0] init_word,
  input  logic [1:0]   fault_mode,
  input  logic [K-1:0] fault_idx,
  input  logic         stuck_val,
  output logic         lut_out,
  output logic [N-1:0] eff_word
);
  lutf_pkg::fmode_e mode_e;
  logic [N-1:0]     eff_comb;
  logic             out_comb;

  assign mode_e = lutf_pkg::fmode_e'(fault_mode);

  lutf_fault_map #(.K(K)) u_map (
    .init_word (init_word),
    .mode      (mode_e),
    .idx       (fault_idx),
    .sval      (stuck_val),
    .eff       (eff_comb)
  );

  lutf_select #(.K(K)) u_sel (
    .table_bits (eff_comb),
    .addr       (lut_in),
    .bit_out    (out_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lut_out  <= 1'b0;
      eff_word <= '0;
    end else begin
      lut_out  <= out_comb;
      eff_word <= eff_comb;
    end
  end
endmodule

// File: rtl/lutf_cell_chk.sv
module lutf_cell_chk #(
  parameter int K = 4,
  localparam int N = 1 << K
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] lut_in,
  input logic [N-1:0] init_word,
  input logic [1:0]   fault_mode,
  input logic [K-1:0] fault_idx,
  input logic         stuck_val,
  input logic         lut_out,
  input logic [N-1:0] eff_word
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (lut_out == 1'b0 && eff_word == '0));

  p_no_fault_r2: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 2'd0) |=> (eff_word == $past(init_word)));

  p_single_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 2'd1) |=> ($countones(eff_word ^ $past(init_word)) == 1));

  p_flip_position_r3: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 2'd1) |=> (eff_word[$past(fault_idx)] != $past(init_word[fault_idx])));

  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 2'd2 && 32'(fault_idx) >= K) |=> (eff_word == $past(init_word)));

  p_out_stuck_r6: assert property (@(posedge clk) disable iff (rst)
    (fault_mode == 2'd3) |=> (eff_word == {N{$past(stuck_val)}}));

  p_read_bit_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lut_out == eff_word[$past(lut_in)]));
endmodule

bind lutf_cell lutf_cell_chk #(.K(K)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lut_in     (lut_in),
  .init_word  (init_word),
  .fault_mode (fault_mode),
  .fault_idx  (fault_idx),
  .stuck_val  (stuck_val),
  .lut_out    (lut_out),
  .eff_word   (eff_word)
);

// File: tb/test_lutf_cell.sv
module test_lutf_cell;
  localparam int CLK_PERIOD = 10;
  localparam int K = 3;
  localparam int N = 1 << K;
  localparam int NV = 12;

  // entry: mode(2) idx(3) sval(1) init(8) x(3) exp_eff(8) exp_y(1)
  localparam logic [25:0] TBL [NV] = '{
    {2'd0, 3'd0, 1'b0, 8'hFE, 3'd0, 8'hFE, 1'b0},  // R2
    {2'd0, 3'd0, 1'b0, 8'hFE, 3'd5, 8'hFE, 1'b1},  // R2
    {2'd1, 3'd7, 1'b0, 8'hFE, 3'd7, 8'h7E, 1'b0},  // R3
    {2'd1, 3'd0, 1'b0, 8'hFE, 3'd0, 8'hFF, 1'b1},  // R3
    {2'd3, 3'd0, 1'b1, 8'hFE, 3'd0, 8'hFF, 1'b1},  // R6
    {2'd3, 3'd0, 1'b0, 8'hFE, 3'd6, 8'h00, 1'b0},  // R6
    {2'd2, 3'd0, 1'b0, 8'hFE, 3'd1, 8'hFC, 1'b0},  // R4
    {2'd2, 3'd1, 1'b0, 8'hFE, 3'd2, 8'hFA, 1'b0},  // R4
    {2'd2, 3'd2, 1'b1, 8'hFE, 3'd0, 8'hFF, 1'b1},  // R4
    {2'd2, 3'd5, 1'b1, 8'hFE, 3'd0, 8'hFE, 1'b0},  // R5
    {2'd1, 3'd3, 1'b0, 8'h80, 3'd3, 8'h88, 1'b1},  // R3
    {2'd2, 3'd0, 1'b1, 8'h96, 3'd2, 8'hC3, 1'b0}   // R4
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] lut_in = '0;
  logic [N-1:0] init_word = '0;
  logic [1:0]   fault_mode = '0;
  logic [K-1:0] fault_idx = '0;
  logic         stuck_val = 1'b0;
  logic         lut_out;
  logic [N-1:0] eff_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lutf_cell #(.K(K)) i_lutf_cell (
    .clk(clk), .rst(rst), .lut_in(lut_in), .init_word(init_word),
    .fault_mode(fault_mode), .fault_idx(fault_idx), .stuck_val(stuck_val),
    .lut_out(lut_out), .eff_word(eff_word)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, result visible at the next falling edge
  task automatic apply(input logic [1:0] m, input logic [K-1:0] i, input logic s,
                       input logic [N-1:0] w, input logic [K-1:0] x);
    @(negedge clk);
    fault_mode = m; fault_idx = i; stuck_val = s; init_word = w; lut_in = x;
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] word_a;
    rst = 1'b1;
    init_word = 8'hFF; fault_mode = 2'd3; stuck_val = 1'b1; lut_in = 3'd7;
    repeat (3) @(negedge clk);
    check("R1 eff", eff_word, '0);
    check("R1 out", {7'd0, lut_out}, '0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      apply(TBL[v][25:24], TBL[v][23:21], TBL[v][20], TBL[v][19:12], TBL[v][11:9]);
      check($sformatf("R2-R6 row %0d eff", v), eff_word, TBL[v][8:1]);
      check($sformatf("R7 row %0d out", v), {7'd0, lut_out}, {7'd0, TBL[v][0]});
    end

    // R7: walk every address of an XOR3 table with no fault
    for (int a = 0; a < N; a++) begin
      apply(2'd0, 3'd0, 1'b0, 8'h96, 3'(a));
      check("R7 walk", {7'd0, lut_out}, {7'd0, ^3'(a)});
    end

    // R4: input 1 stuck at 1 makes the output ignore lut_in bit 1
    apply(2'd2, 3'd1, 1'b1, 8'h96, 3'd0);
    word_a = {7'd0, lut_out};
    apply(2'd2, 3'd1, 1'b1, 8'h96, 3'd2);
    check("R4 input ignored", {7'd0, lut_out}, word_a);

    // R8: inverting bit 0 of OR3 equals output stuck-at-1
    apply(2'd1, 3'd0, 1'b0, 8'hFE, 3'd0);
    word_a = eff_word;
    apply(2'd3, 3'd0, 1'b1, 8'hFE, 3'd0);
    check("R8 duplicate", {7'd0, (eff_word == word_a)}, 8'd1);
    apply(2'd1, 3'd7, 1'b0, 8'hFE, 3'd0);
    check("R8 distinct", {7'd0, (eff_word == word_a)}, 8'd0);

    // R1: reset mid-run clears outputs
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 midrun", eff_word, '0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule